// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block collects transfer requests for four DMA channels and hands the system bus to one channel at a time. Each channel keeps a single request flag. A 2-bit per-channel source field selects what sets the flag: either a one-cycle internal event pulse, or an edge on that channel's external interrupt pin. The pin first passes through a two-flop synchronizer. A channel whose enable bit is low keeps its flag but is never picked.

Channel 0 has the highest fixed priority and channel 3 the lowest. The flag of the chosen channel is cleared on the same clock edge that raises the grant. After each single transfer the bus goes back to the CPU for exactly one access. The next pending channel is granted on the edge where that access completes. Address generation, transfer counting and the data path belong to neighbouring blocks.

The controller is a three-state machine:
- **ST_IDLE**: the CPU owns the bus and nothing is granted.
- **ST_XFER**: a channel owns the bus.
- **ST_CPU**: the bus has been returned for one mandatory CPU access.

Its transitions are:
- **T_GRANT** (ST_IDLE to ST_XFER): an enabled flag is set.
- **T_RELEASE** (ST_XFER to ST_CPU): `xfer_done_i` is high.
- **T_NEXT** (ST_CPU to ST_XFER): `cpu_done_i` is high and an enabled flag is set.
- **T_REST** (ST_CPU to ST_IDLE): `cpu_done_i` is high and nothing is eligible.

Top module: `dma_req_arbiter`

## Requirements
- R1: At each grant decision the lowest-numbered channel whose flag and enable are both 1 is granted. A higher-priority request never interrupts a transfer already granted.
- R2: Requests for several channels sampled on the same clock edge set all of their flags on that edge.
- R3: With source field 00 (internal), a high `evt_int_i[c]` sampled at a rising clock edge sets flag c at that edge. Activity on `ext_pin_i[c]` is ignored in this mode.
- R4: Source field values 01, 10 and 11 select the pin's falling edge, rising edge and both edges. A pin change made before edge E1 sets the flag at edge E3, counting two synchronizer flops and one edge-detect flop. The non-selected edge and `evt_int_i[c]` are ignored.
- R5: The granted channel's flag clears on the same edge that raises `bus_grant_o`. A new request for that channel sampled on that same edge leaves the flag set.
- R6: The grant holds, with `grant_ch_o` stable, until `xfer_done_i` is sampled high; `bus_grant_o` falls at that edge. No grant follows until `cpu_done_i` is sampled high. At that edge the next eligible channel is granted directly.
- R7: A channel with its enable low keeps its flag and is never granted. It is granted on the first edge after its enable rises, if the bus is free.
- R8: A second request arriving while a flag is already set merges into it, so only one transfer results.
- R9: With no eligible flag, `bus_grant_o` stays 0 and `grant_ch_o` reads 0.
- R10: After reset all flags are 0 and `bus_grant_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_int_i | input | NUM_CH | Internal event pulse per channel |
| ext_pin_i | input | NUM_CH | Asynchronous external interrupt pin per channel |
| ch_en_i | input | NUM_CH | Channel enable bits |
| src_sel_i | input | 2*NUM_CH | Source field per channel, channel c at bits [2c+1:2c] |
| xfer_done_i | input | 1 | The granted channel finished its transfer |
| cpu_done_i | input | 1 | The CPU finished its bus access |
| bus_grant_o | output | 1 | A DMA channel owns the bus |
| grant_ch_o | output | CH_W | Index of the granted channel, 0 when no grant |
| pend_o | output | NUM_CH | Request flags |

## Verification
The bench raises three requests in one cycle and then holds the CPU access open for several cycles. An arbiter without the CPU gap would grant the second channel at once. One with a wrong priority order would pick channel 1 or 3 first. It launches a new request in the very cycle that channel's grant begins; a design where clearing wins would silently lose that request. The pin tests check the exact third edge and each polarity in turn. A miswired synchronizer, or a design that fires on the wrong edge or leaks the internal pulse through, sets the flag at the wrong time or not at all.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_CPU  = 2'd2
    } arb_state_e;

    typedef enum logic [1:0] {
        SRC_INT  = 2'b00,
        SRC_FALL = 2'b01,
        SRC_RISE = 2'b10,
        SRC_BOTH = 2'b11
    } src_sel_e;

endpackage

// File: rtl/dma_pin_edge.sv
// Synchronizes one asynchronous pin and reports its edges.
module dma_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[SH_W-2:0], pin_i};
        end
    end

    // sh_q[SYNC_STAGES-1] is the synchronized level and sh_q[SYNC_STAGES] its previous value.
    always_comb begin
        rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
        fall_o = ~sh_q[SYNC_STAGES-1] & sh_q[SYNC_STAGES];
    end
endmodule

// File: rtl/dma_req_latch.sv
// One request flag per channel. A set on the same edge as a clear wins.
module dma_req_latch
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CH-1:0]     evt_int_i,
    input  logic [NUM_CH-1:0]     rise_i,
    input  logic [NUM_CH-1:0]     fall_i,
    input  logic [2*NUM_CH-1:0]   src_sel_i,
    input  logic [NUM_CH-1:0]     clr_i,
    output logic [NUM_CH-1:0]     flag_o
);
    logic [NUM_CH-1:0] set_w;
    logic [NUM_CH-1:0] flag_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        src_sel_e sel_w;

        always_comb begin
            sel_w = src_sel_e'(src_sel_i[2*c +: 2]);
            unique case (sel_w)
                SRC_INT:  set_w[c] = evt_int_i[c];
                SRC_FALL: set_w[c] = fall_i[c];
                SRC_RISE: set_w[c] = rise_i[c];
                SRC_BOTH: set_w[c] = rise_i[c] | fall_i[c];
                default:  set_w[c] = 1'b0;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[c] <= 1'b0;
            end else begin
                flag_q[c] <= set_w[c] | (flag_q[c] & ~clr_i[c]);
            end
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/dma_prio_pick.sv
// Fixed-priority pick: the lowest index wins.
module dma_prio_pick #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic [NUM_CH-1:0] req_i,
    output logic              any_o,
    output logic [CH_W-1:0]   idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = CH_W'(i);
            end
        end
    end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter  int NUM_CH      = 4,
    parameter  int SYNC_STAGES = 2,
    localparam int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CH-1:0]     evt_int_i,
    input  logic [NUM_CH-1:0]     ext_pin_i,
    input  logic [NUM_CH-1:0]     ch_en_i,
    input  logic [2*NUM_CH-1:0]   src_sel_i,
    input  logic                  xfer_done_i,
    input  logic                  cpu_done_i,
    output logic                  bus_grant_o,
    output logic [CH_W-1:0]       grant_ch_o,
    output logic [NUM_CH-1:0]     pend_o
);
    logic [NUM_CH-1:0] rise_w;
    logic [NUM_CH-1:0] fall_w;
    logic [NUM_CH-1:0] clr_w;
    logic [NUM_CH-1:0] flag_w;
    logic [NUM_CH-1:0] elig_w;
    logic              pick_any_w;
    logic [CH_W-1:0]   pick_idx_w;
    logic              launch_w;
    arb_state_e        st_q;
    arb_state_e        st_d;
    logic [CH_W-1:0]   cur_ch_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_pin
        dma_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (ext_pin_i[c]),
            .rise_o (rise_w[c]),
            .fall_o (fall_w[c])
        );
    end

    dma_req_latch #(.NUM_CH(NUM_CH)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_int_i (evt_int_i),
        .rise_i    (rise_w),
        .fall_i    (fall_w),
        .src_sel_i (src_sel_i),
        .clr_i     (clr_w),
        .flag_o    (flag_w)
    );

    assign elig_w = flag_w & ch_en_i;

    dma_prio_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
        .req_i (elig_w),
        .any_o (pick_any_w),
        .idx_o (pick_idx_w)
    );

    // Next state: T_GRANT, T_RELEASE, T_NEXT, T_REST.
    always_comb begin
        st_d     = st_q;
        launch_w = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (pick_any_w) begin
                    st_d     = ST_XFER;
                    launch_w = 1'b1;
                end
            end
            ST_XFER: begin
                if (xfer_done_i) begin
                    st_d = ST_CPU;
                end
            end
            ST_CPU: begin
                if (cpu_done_i) begin
                    if (pick_any_w) begin
                        st_d     = ST_XFER;
                        launch_w = 1'b1;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            cur_ch_q <= '0;
        end else begin
            st_q <= st_d;
            if (launch_w) begin
                cur_ch_q <= pick_idx_w;
            end
        end
    end

    always_comb begin
        clr_w = '0;
        if (launch_w) begin
            clr_w[pick_idx_w] = 1'b1;
        end
    end

    always_comb begin
        bus_grant_o = (st_q == ST_XFER);
        grant_ch_o  = bus_grant_o ? cur_ch_q : '0;
        pend_o      = flag_w;
    end
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] ch_en_i,
    input logic              xfer_done_i,
    input logic              cpu_done_i,
    input logic              bus_grant_o,
    input logic [CH_W-1:0]   grant_ch_o,
    input logic [NUM_CH-1:0] pend_o,
    input arb_state_e        st_i
);
    logic [NUM_CH-1:0] elig_q;
    logic [NUM_CH-1:0] below_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elig_q <= '0;
        end else begin
            elig_q <= pend_o & ch_en_i;
        end
    end

    always_comb begin
        below_w = (NUM_CH'(1) << grant_ch_o) - NUM_CH'(1);
    end

    assert_prio_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_grant_o) |-> ((elig_q & below_w) == '0));

    assert_grant_eligible_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_grant_o) |-> elig_q[grant_ch_o]);

    assert_hold_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant_o && !xfer_done_i) |=> (bus_grant_o && $stable(grant_ch_o)));

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant_o && xfer_done_i) |=> !bus_grant_o);

    assert_cpu_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_i == ST_CPU) && !cpu_done_i) |=> !bus_grant_o);

    assert_no_idle_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_grant_o && ((pend_o & ch_en_i) == '0)) |=> !bus_grant_o);
endmodule

bind dma_req_arbiter dma_arb_checker #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ch_en_i     (ch_en_i),
    .xfer_done_i (xfer_done_i),
    .cpu_done_i  (cpu_done_i),
    .bus_grant_o (bus_grant_o),
    .grant_ch_o  (grant_ch_o),
    .pend_o      (pend_o),
    .st_i        (st_q)
);

// File: tb/dma_req_arbiter_bench.sv
module dma_req_arbiter_bench;
    localparam int NUM_CH = 4;
    localparam int CH_W   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] evt_int = '0;
    logic [NUM_CH-1:0] ext_pin = '0;
    logic [NUM_CH-1:0] ch_en = '0;
    logic [2*NUM_CH-1:0] src_sel = '0;
    logic              xfer_done = 1'b0;
    logic              cpu_done = 1'b0;
    logic              bus_grant;
    logic [CH_W-1:0]   grant_ch;
    logic [NUM_CH-1:0] pend;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dma_req_arbiter u_dma_req_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_int_i   (evt_int),
        .ext_pin_i   (ext_pin),
        .ch_en_i     (ch_en),
        .src_sel_i   (src_sel),
        .xfer_done_i (xfer_done),
        .cpu_done_i  (cpu_done),
        .bus_grant_o (bus_grant),
        .grant_ch_o  (grant_ch),
        .pend_o      (pend)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_grant(input string tag, input int ch);
        chk({tag, " grant"}, int'(bus_grant), 1);
        chk({tag, " channel"}, int'(grant_ch), ch);
    endtask

    // End the transfer, then check the bus is back with the CPU.
    task automatic finish_xfer(input string tag);
        xfer_done = 1'b1;
        step(1);
        xfer_done = 1'b0;
        chk({tag, " released"}, int'(bus_grant), 0);
    endtask

    task automatic cpu_access;
        cpu_done = 1'b1;
        step(1);
        cpu_done = 1'b0;
    endtask

    task automatic test_reset;
        chk("R10 flags after reset", int'(pend), 0);
        chk("R10 grant after reset", int'(bus_grant), 0);
        chk("R9 channel idle", int'(grant_ch), 0);
    endtask

    task automatic test_internal_single;
        ch_en = 4'b1111;
        evt_int = 4'b0100;
        step(1);
        evt_int = '0;
        chk("R3 flag set at sampled edge", int'(pend), 4'b0100);
        chk("R3 no grant yet", int'(bus_grant), 0);
        step(1);
        expect_grant("R5 ch2", 2);
        chk("R5 flag cleared at grant", int'(pend), 0);
        step(2);
        expect_grant("R6 held", 2);
        finish_xfer("R6");
        cpu_access();
        chk("R9 nothing pending", int'(bus_grant), 0);
    endtask

    task automatic test_simultaneous;
        evt_int = 4'b1011;
        step(1);
        evt_int = '0;
        chk("R2 flags together", int'(pend), 4'b1011);
        step(1);
        expect_grant("R1 first ch0", 0);
        chk("R5 only ch0 cleared", int'(pend), 4'b1010);
        finish_xfer("R6 ch0");
        step(3);
        chk("R6 waits for cpu access", int'(bus_grant), 0);
        chk("R6 flags kept", int'(pend), 4'b1010);
        cpu_access();
        expect_grant("R6 next on cpu done ch1", 1);
        chk("R1 ch3 still waits", int'(pend), 4'b1000);
        finish_xfer("R6 ch1");
        cpu_access();
        expect_grant("R1 last ch3", 3);
        finish_xfer("R6 ch3");
        cpu_access();
        step(3);
        chk("R9 grant stays low", int'(bus_grant), 0);
        chk("R9 channel zero", int'(grant_ch), 0);
    endtask

    task automatic test_no_preempt;
        evt_int = 4'b1000;
        step(1);
        evt_int = '0;
        step(1);
        expect_grant("R1 ch3 granted", 3);
        evt_int = 4'b0001;
        step(1);
        evt_int = '0;
        step(1);
        expect_grant("R1 no preempt", 3);
        chk("R1 ch0 pending", int'(pend), 4'b0001);
        finish_xfer("R1");
        cpu_access();
        expect_grant("R1 ch0 after gap", 0);
        finish_xfer("R1 ch0");
        cpu_access();
    endtask

    task automatic test_disabled;
        ch_en = 4'b1101;
        evt_int = 4'b0010;
        step(1);
        evt_int = '0;
        step(4);
        chk("R7 flag kept", int'(pend), 4'b0010);
        chk("R7 not granted", int'(bus_grant), 0);
        ch_en = 4'b1111;
        step(1);
        expect_grant("R7 granted on enable", 1);
        finish_xfer("R7");
        cpu_access();
    endtask

    task automatic test_merge;
        ch_en = 4'b1110;
        evt_int = 4'b0001;
        step(1);
        evt_int = '0;
        step(1);
        evt_int = 4'b0001;
        step(1);
        evt_int = '0;
        chk("R8 single flag", int'(pend), 4'b0001);
        ch_en = 4'b1111;
        step(1);
        expect_grant("R8 ch0", 0);
        finish_xfer("R8");
        cpu_access();
        step(2);
        chk("R8 no second transfer", int'(bus_grant), 0);
        chk("R8 no flag left", int'(pend), 0);
    endtask

    task automatic test_set_on_clear;
        ch_en = 4'b1011;
        evt_int = 4'b0100;
        step(1);
        evt_int = '0;
        step(1);
        chk("R7 ch2 held pending", int'(pend), 4'b0100);
        ch_en = 4'b1111;
        evt_int = 4'b0100;
        step(1);
        evt_int = '0;
        expect_grant("R5 ch2", 2);
        chk("R5 new request survives clear", int'(pend), 4'b0100);
        finish_xfer("R5");
        cpu_access();
        expect_grant("R5 ch2 again", 2);
        chk("R5 cleared second time", int'(pend), 0);
        finish_xfer("R5 again");
        cpu_access();
    endtask

    // Serve a pending channel so its flag returns to 0; enables go back to 0.
    task automatic serve(input int ch);
        ch_en = '0;
        ch_en[ch] = 1'b1;
        step(1);
        expect_grant("R4 serve", ch);
        ch_en = '0;
        finish_xfer("R4 serve");
        cpu_access();
    endtask

    task automatic test_external;
        ch_en = '0;
        src_sel = {2'b11, 2'b00, 2'b10, 2'b01};
        ext_pin[2] = 1'b1;
        step(5);
        ext_pin[2] = 1'b0;
        step(5);
        chk("R3 pin ignored in internal mode", int'(pend), 0);
        evt_int = 4'b0001;
        step(1);
        evt_int = '0;
        step(1);
        chk("R4 internal pulse ignored", int'(pend), 0);
        ext_pin[0] = 1'b1;
        step(5);
        chk("R4 rise ignored on falling source", int'(pend), 0);
        ext_pin[0] = 1'b0;
        step(2);
        chk("R4 not before third edge", int'(pend), 0);
        step(1);
        chk("R4 falling edge at third edge", int'(pend), 4'b0001);
        serve(0);
        ext_pin[1] = 1'b1;
        step(2);
        chk("R4 rise not before third edge", int'(pend), 0);
        step(1);
        chk("R4 rising edge sets", int'(pend), 4'b0010);
        serve(1);
        ext_pin[1] = 1'b0;
        step(5);
        chk("R4 fall ignored on rising source", int'(pend), 0);
        ext_pin[3] = 1'b1;
        step(3);
        chk("R4 both: rise sets", int'(pend), 4'b1000);
        serve(3);
        ext_pin[3] = 1'b0;
        step(3);
        chk("R4 both: fall sets", int'(pend), 4'b1000);
        serve(3);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        test_reset();
        test_internal_single();
        test_simultaneous();
        test_no_preempt();
        test_disabled();
        test_merge();
        test_set_on_clear();
        test_external();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule